// File: doc/BRIEF.md
# Sampling Converter Serial Port Slave

This block models the digital side of the synchronous serial port of an eight-input, 12-bit sampling converter. It runs on a fast system clock and treats the serial clock, the active-low select and the serial data input as asynchronous pins. It brings them into its own clock domain, hunts for a start bit, and decodes the control byte that follows. It reports the multiplexer routing and the power state on status outputs, and returns a conversion result that it takes from a per-channel digital code bus. The output data and busy pins have separate enable outputs that stand in for high impedance.

Each conversion has a fixed position relative to its own start bit, so result shifting and command reception run independently. A host can send the next control byte while the previous result is still being shifted out. Frames of 24, 16 or 15 serial clocks all work. The system clock must run at least eight times faster than the serial clock.

Top module: `adcs_serial_slave`

## Requirements
- R1: After reset with select high: data and busy outputs low, both enables low, power state 1 (doze), positive select 0, negative select 8 (common).
- R2: While select is low, serial data is sampled on serial clock rising edges. Low bits are ignored until the first high bit, which is rising edge 1 of a frame.
- R3: The control byte is sent MSB first: start, A2, A1, A0, an unused bit, single/differential flag, PD1, PD0. With the flag high, the positive select becomes A2..A0 and the negative select becomes 8. The select outputs change only after rising edge 6 of the frame.
- R4: With the flag low, channels form the pairs (0,1), (2,3), (4,5) and (6,7), and A1..A0 choose the pair. A2=0 makes the even channel positive and the odd channel negative; A2=1 swaps them.
- R5: Busy is high for exactly one serial clock: from the falling edge after rising edge 8 until the falling edge after rising edge 9.
- R6: At rising edge 8, the code of the positive channel (straight binary, 0 to 4095) is captured. It leaves the device MSB first, one bit per falling edge, on the falling edges after rising edges 9 through 20. The data output is 0 on every later falling edge of the frame.
- R7: Serial data on rising edges 9 to 15 of a frame is ignored. A new start bit is accepted from rising edge 16 onward. This allows 15- and 16-clock framing, with the new control byte overlapping the previous result.
- R8: Power state (0 shutdown, 1 doze, 2 on): with PD = 00 the state is 2 from rising edge 6 until the LSB has been sent, and 1 otherwise. PD = 11, 01 or 10 gives 2 continuously. PD takes effect at rising edge 8.
- R9: A low shutdown input forces power state 0 at once, whatever the mode.
- R10: Select high drives both enables low and both data outputs low, abandons any frame in progress, and ignores serial clock edges. A full frame sent after select falls again decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low select |
| din_i | input | 1 | Serial command data |
| shdn_n_i | input | 1 | Active-low shutdown |
| code_bus_i | input | 8*DW | Conversion code per channel, channel n at bits n*DW and up |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Enable for dout_o (low means high impedance) |
| busy_o | output | 1 | Conversion busy flag |
| busy_oe_o | output | 1 | Enable for busy_o |
| pos_sel_o | output | 4 | Positive input select, 0-7 channel |
| neg_sel_o | output | 4 | Negative input select, 0-7 channel, 8 common |
| pwr_o | output | 2 | Power state: 0 shutdown, 1 doze, 2 on |

## Verification
The hardest condition to reach is the overlap. A new control byte arrives while the previous result is still leaving the device. At the same time, high bits fall inside the window where they must be ignored. The stimulus reaches this by sending a frame whose bits 9 to 15 are all ones, followed by a second control byte on rising edge 16 or 17. The bench then checks that both results come out intact and that the multiplexer select did not move on the ignored bits. Select-abort is reached by raising select in the middle of a control byte and toggling the serial clock with data high before the next frame.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    // Channel count and control layout are fixed by the control byte format
    localparam int NUM_CH    = 8;
    localparam int CH_W      = 3;
    localparam int SEL_W     = 4;
    localparam int CTRL_BITS = 8;
    localparam logic [SEL_W-1:0] SEL_COM = 4'd8;

    typedef enum logic [1:0] {
        PWR_SHUT = 2'd0,
        PWR_DOZE = 2'd1,
        PWR_ON   = 2'd2
    } pwr_e;

    // Returns {positive select, negative select} for a channel field and mode flag
    function automatic logic [2*SEL_W-1:0] mux_decode(input logic [CH_W-1:0] ch,
                                                      input logic single);
        logic [SEL_W-1:0] even_sel;
        logic [SEL_W-1:0] odd_sel;
        even_sel = {1'b0, ch[CH_W-2:0], 1'b0};
        odd_sel  = {1'b0, ch[CH_W-2:0], 1'b1};
        if (single)
            return {1'b0, ch, SEL_COM};
        else if (ch[CH_W-1])
            return {odd_sel, even_sel};
        else
            return {even_sel, odd_sel};
    endfunction
endpackage

// File: rtl/adcs_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module adcs_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pins through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adcs_ctrl_rx.sv
// Command receiver: hunts for the start bit, counts serial rising edges of
// the frame, decodes the multiplexer routing and power-down field.
// Assumes rise_i is a one-cycle pulse already gated by an active select.
module adcs_ctrl_rx
    import adcs_pkg::*;
#(
    parameter int FRAME_MIN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act_i,
    input  logic             rise_i,
    input  logic             sdi_i,
    output logic [SEL_W-1:0] pos_sel_o,
    output logic [SEL_W-1:0] neg_sel_o,
    output logic [1:0]       pd_o,
    output logic             conv_start_o,
    output logic             acq_o
);
    localparam int CNT_W    = $clog2(FRAME_MIN + 1) + 1;
    localparam int LAST_CTL = CTRL_BITS - 1;  // count held before the final control bit
    localparam int SGL_AT   = 5;              // count held before the mode flag

    logic             hunting_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       sr_q;
    logic             hunt_now;

    // A start bit may be taken while idle or once the minimum frame has elapsed
    assign hunt_now     = hunting_q || (cnt_q == CNT_W'(FRAME_MIN));
    assign conv_start_o = rise_i && !hunt_now && (cnt_q == CNT_W'(LAST_CTL));
    assign acq_o        = !hunting_q && (cnt_q >= CNT_W'(SGL_AT + 1))
                          && (cnt_q <= CNT_W'(LAST_CTL));

    // Frame counter, control shift register and decoded outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunting_q <= 1'b1;
            cnt_q     <= '0;
            sr_q      <= '0;
            pos_sel_o <= '0;
            neg_sel_o <= SEL_COM;
            pd_o      <= 2'b00;
        end else if (!cs_act_i) begin
            hunting_q <= 1'b1;
            cnt_q     <= '0;
        end else if (rise_i) begin
            if (hunt_now) begin
                hunting_q <= !sdi_i;
                cnt_q     <= sdi_i ? CNT_W'(1) : '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q < CNT_W'(LAST_CTL))
                    sr_q <= {sr_q[2:0], sdi_i};
                if (cnt_q == CNT_W'(SGL_AT))
                    {pos_sel_o, neg_sel_o} <= mux_decode(sr_q[3:1], sdi_i);
                if (cnt_q == CNT_W'(LAST_CTL))
                    pd_o <= {sr_q[0], sdi_i};
            end
        end
    end

    // R4: a differential route always names the two members of one pair
    p_pair_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_sel_o != SEL_COM) |->
            (pos_sel_o[SEL_W-1:1] == neg_sel_o[SEL_W-1:1]) && (pos_sel_o[0] != neg_sel_o[0]));

    // R3: routing moves only on a serial rising edge
    p_mux_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(pos_sel_o) && $stable(neg_sel_o));

    // R7: an open frame never counts past the point where hunting resumes
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hunting_q |-> (cnt_q <= CNT_W'(FRAME_MIN)) && (cnt_q != '0));
endmodule

// File: rtl/adcs_result_tx.sv
// Result transmitter: on a load pulse captures the code, then on successive
// serial falling edges raises busy for one period, shifts the code out MSB
// first and drives zero afterwards. Assumes fall_i is gated by the select.
module adcs_result_tx #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act_i,
    input  logic          fall_i,
    input  logic          load_i,
    input  logic [DW-1:0] code_i,
    output logic          sdo_o,
    output logic          busy_o,
    output logic          active_o
);
    localparam int LEFT_W = $clog2(DW);

    logic              armed_q;
    logic              busy_q;
    logic              shift_q;
    logic              sdo_q;
    logic [DW-1:0]     sr_q;
    logic [LEFT_W-1:0] left_q;

    // Sequence: armed -> busy -> shifting -> idle, advanced on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            busy_q  <= 1'b0;
            shift_q <= 1'b0;
            sdo_q   <= 1'b0;
            sr_q    <= '0;
            left_q  <= '0;
        end else if (!cs_act_i) begin
            armed_q <= 1'b0;
            busy_q  <= 1'b0;
            shift_q <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (load_i) begin
            armed_q <= 1'b1;
            sr_q    <= code_i;
        end else if (fall_i) begin
            if (armed_q) begin
                armed_q <= 1'b0;
                busy_q  <= 1'b1;
                sdo_q   <= 1'b0;
            end else if (busy_q) begin
                busy_q  <= 1'b0;
                shift_q <= 1'b1;
                sdo_q   <= sr_q[DW-1];
                sr_q    <= sr_q << 1;
                left_q  <= LEFT_W'(DW - 1);
            end else if (shift_q) begin
                if (left_q != '0) begin
                    sdo_q  <= sr_q[DW-1];
                    sr_q   <= sr_q << 1;
                    left_q <= left_q - 1'b1;
                end else begin
                    sdo_q   <= 1'b0;
                    shift_q <= 1'b0;
                end
            end
        end
    end

    assign sdo_o    = sdo_q;
    assign busy_o   = busy_q;
    assign active_o = armed_q || busy_q || shift_q;

    // R5: busy never survives a second falling edge
    p_busy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && fall_i |=> !busy_q);

    // R6: the falling edge that clears busy starts the result shift
    p_busy_then_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && fall_i |=> shift_q);
endmodule

// File: rtl/adcs_serial_slave.sv
// Top level of the serial converter slave: synchronises the pins, detects
// serial clock edges, and joins the command receiver, the result transmitter
// and the power-state decode. Assumes clk is at least 8x the serial clock.
module adcs_serial_slave
    import adcs_pkg::*;
#(
    parameter int DW = 12,
    parameter int FRAME_MIN = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dclk_i,
    input  logic                 cs_n_i,
    input  logic                 din_i,
    input  logic                 shdn_n_i,
    input  logic [NUM_CH*DW-1:0] code_bus_i,
    output logic                 dout_o,
    output logic                 dout_oe_o,
    output logic                 busy_o,
    output logic                 busy_oe_o,
    output logic [SEL_W-1:0]     pos_sel_o,
    output logic [SEL_W-1:0]     neg_sel_o,
    output logic [1:0]           pwr_o
);
    logic [2:0]    pins_s;
    logic          dclk_s, csn_s, din_s, dclk_d_q;
    logic          cs_act, rise, fall;
    logic [1:0]    pd;
    logic          conv_start, acq, tx_active, sdo, busy;
    logic [DW-1:0] code;
    pwr_e          pwr;

    adcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({din_i, cs_n_i, dclk_i}), .q_o(pins_s));

    assign {din_s, csn_s, dclk_s} = pins_s;
    assign cs_act = !csn_s;

    // Delayed copy of the synchronised serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_d_q <= 1'b0;
        else        dclk_d_q <= dclk_s;
    end

    assign rise = cs_act && dclk_s && !dclk_d_q;
    assign fall = cs_act && !dclk_s && dclk_d_q;

    adcs_ctrl_rx #(.FRAME_MIN(FRAME_MIN)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .rise_i(rise), .sdi_i(din_s),
        .pos_sel_o(pos_sel_o), .neg_sel_o(neg_sel_o), .pd_o(pd),
        .conv_start_o(conv_start), .acq_o(acq));

    assign code = code_bus_i[int'(pos_sel_o[CH_W-1:0]) * DW +: DW];

    adcs_result_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .fall_i(fall), .load_i(conv_start),
        .code_i(code), .sdo_o(sdo), .busy_o(busy), .active_o(tx_active));

    // Power state: shutdown pin wins, then mode field and activity
    always_comb begin
        if (!shdn_n_i)                          pwr = PWR_SHUT;
        else if (pd != 2'b00 || acq || tx_active) pwr = PWR_ON;
        else                                    pwr = PWR_DOZE;
    end

    assign pwr_o     = pwr;
    assign dout_oe_o = cs_act;
    assign busy_oe_o = cs_act;
    assign dout_o    = cs_act && sdo;
    assign busy_o    = cs_act && busy;

    // R8: in doze the pins carry no busy flag and no result data
    p_doze_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o == PWR_DOZE) |-> !busy_o && !dout_o);
endmodule

// File: tb/test_adcs_serial_slave.sv
module test_adcs_serial_slave;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk = 1'b0, cs_n = 1'b1, din = 1'b0, shdn_n = 1'b1;
    logic [8*DW-1:0] code_bus;
    logic dout, dout_oe, busy, busy_oe;
    logic [3:0] pos_sel, neg_sel;
    logic [1:0] pwr;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic       stim     [64];
    logic       rec_sdo  [64];
    logic       rec_busy [64];
    logic [1:0] rec_pwr  [64];
    logic [3:0] rec_ps   [64];
    logic [3:0] rec_ns   [64];

    always #5 clk = ~clk;

    adcs_serial_slave #(.DW(DW)) i_adcs_serial_slave (
        .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .cs_n_i(cs_n), .din_i(din),
        .shdn_n_i(shdn_n), .code_bus_i(code_bus), .dout_o(dout), .dout_oe_o(dout_oe),
        .busy_o(busy), .busy_oe_o(busy_oe), .pos_sel_o(pos_sel), .neg_sel_o(neg_sel),
        .pwr_o(pwr));

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] code_of(input int ch);
        return code_bus[ch*DW +: DW];
    endfunction

    function automatic logic [7:0] ctl(input logic [2:0] ch, input logic sgl,
                                       input logic [1:0] pd);
        return {1'b1, ch, 1'b0, sgl, pd};
    endfunction

    task automatic clear_stim();
        for (int i = 0; i < 64; i++) stim[i] = 1'b0;
    endtask

    task automatic put_byte(input int at, input logic [7:0] b);
        for (int i = 0; i < 8; i++) stim[at+i] = b[7-i];
    endtask

    // One serial clock per entry; samples after each rising and falling edge
    task automatic run_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            din = stim[i];
            repeat (2) @(negedge clk);
            dclk = 1'b1;
            repeat (6) @(negedge clk);
            rec_ps[i] = pos_sel;
            rec_ns[i] = neg_sel;
            repeat (2) @(negedge clk);
            dclk = 1'b0;
            repeat (6) @(negedge clk);
            rec_sdo[i]  = dout;
            rec_busy[i] = busy;
            rec_pwr[i]  = pwr;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        din = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Sends one 24-clock frame after `lead` zero bits and checks routing, busy and data
    task automatic run_frame(input int lead, input logic [2:0] ch, input logic sgl,
                             input logic [1:0] pd, input int exp_pos, input int exp_neg,
                             input string req);
        logic [DW-1:0] exp_code;
        clear_stim();
        put_byte(lead, ctl(ch, sgl, pd));
        cs_low();
        chk("R10", "output enable with select low", {dout_oe, busy_oe}, 2'b11);
        run_clocks(lead + 24);
        exp_code = code_of(exp_pos);
        chk(req, "positive select after edge 6", rec_ps[lead+5], exp_pos);
        chk(req, "negative select after edge 6", rec_ns[lead+5], exp_neg);
        chk("R5", "busy before edge 8 fall", rec_busy[lead+6], 0);
        chk("R5", "busy after edge 8 fall", rec_busy[lead+7], 1);
        chk("R5", "busy after edge 9 fall", rec_busy[lead+8], 0);
        for (int j = 0; j < DW; j++)
            chk("R6", $sformatf("result bit %0d", DW-1-j), rec_sdo[lead+8+j], exp_code[DW-1-j]);
        for (int j = 20; j < 24; j++)
            chk("R6", $sformatf("trailing zero at edge %0d", j+1), rec_sdo[lead+j], 0);
        chk("R8", "power while converting", rec_pwr[lead+10], 2);
        chk("R8", "power at frame end", rec_pwr[lead+23], (pd == 2'b00) ? 1 : 2);
        cs_high();
    endtask

    task automatic t_reset();
        chk("R1", "dout", dout, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "enables", {dout_oe, busy_oe}, 0);
        chk("R1", "power", pwr, 1);
        chk("R1", "positive select", pos_sel, 0);
        chk("R1", "negative select", neg_sel, 8);
    endtask

    task automatic t_single();
        run_frame(3, 3'd5, 1'b1, 2'b11, 5, 8, "R3");
        chk("R3", "select unchanged after edge 5", rec_ps[3+4], 0);
        chk("R2", "frame aligned to first high bit", rec_busy[3+7], 1);
        chk("R2", "no busy during leading zeros", rec_busy[2], 0);
    endtask

    task automatic t_shutdown();
        shdn_n = 1'b0;
        @(negedge clk);
        chk("R9", "power in shutdown", pwr, 0);
        shdn_n = 1'b1;
        @(negedge clk);
        chk("R9", "power after shutdown release", pwr, 2);
    endtask

    task automatic t_boundary();
        run_frame(0, 3'd0, 1'b1, 2'b00, 0, 8, "R3");
        run_frame(0, 3'd7, 1'b1, 2'b00, 7, 8, "R3");
    endtask

    task automatic t_diff();
        run_frame(0, 3'b110, 1'b0, 2'b11, 5, 4, "R4");
        run_frame(0, 3'b001, 1'b0, 2'b11, 2, 3, "R4");
    endtask

    task automatic t_overlap(input int gap);
        logic [DW-1:0] ca, cb;
        ca = code_of(1);
        cb = code_of(6);
        clear_stim();
        put_byte(0, ctl(3'd1, 1'b1, 2'b11));
        for (int i = 8; i < 15; i++) stim[i] = 1'b1;
        put_byte(gap, ctl(3'd6, 1'b1, 2'b11));
        cs_low();
        run_clocks(gap + 24);
        chk("R7", $sformatf("gap %0d ignored high bits keep select", gap), rec_ps[14], 1);
        chk("R7", "first busy", rec_busy[7], 1);
        for (int j = 0; j < DW; j++)
            chk("R7", $sformatf("first result bit %0d", DW-1-j), rec_sdo[8+j], ca[DW-1-j]);
        chk("R7", "second select", rec_ps[gap+5], 6);
        chk("R7", "second busy", rec_busy[gap+7], 1);
        for (int j = 0; j < DW; j++)
            chk("R7", $sformatf("second result bit %0d", DW-1-j), rec_sdo[gap+8+j], cb[DW-1-j]);
        cs_high();
    endtask

    task automatic t_cs_abort();
        logic [3:0] ps0;
        ps0 = pos_sel;
        clear_stim();
        put_byte(0, ctl(3'd3, 1'b0, 2'b11));
        cs_low();
        run_clocks(4);
        cs_high();
        chk("R10", "enables with select high", {dout_oe, busy_oe}, 0);
        chk("R10", "outputs with select high", {dout, busy}, 0);
        for (int i = 0; i < 64; i++) stim[i] = 1'b1;
        cs_n = 1'b1;
        run_clocks(10);
        chk("R10", "select unchanged by edges while deselected", pos_sel, ps0);
        chk("R10", "no busy while deselected", busy, 0);
        run_frame(0, 3'd2, 1'b1, 2'b11, 2, 8, "R10");
    endtask

    task automatic t_reserved();
        run_frame(0, 3'd4, 1'b1, 2'b01, 4, 8, "R8");
        run_frame(0, 3'd3, 1'b1, 2'b10, 3, 8, "R8");
    endtask

    initial begin
        code_bus = {12'hFFF, 12'h3C3, 12'hA5C, 12'hABC, 12'h789, 12'h456, 12'h123, 12'h000};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single();
        t_shutdown();
        t_boundary();
        t_diff();
        t_overlap(15);
        t_overlap(16);
        t_cs_abort();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule